// File: doc/BRIEF.md
# MSI Capability Register Window and Message Generator

This block holds a message-signalled-interrupt capability structure as a six-dword configuration window. It also turns interrupt request pulses from inside the function into message descriptors. Each descriptor carries a target address, a data word, a flag saying whether the address needs the 64-bit form, and the number of the vector that caused it. Configuration software programs the address, the data and the per-vector masks through a 32-bit write port with a dword index. Reads return data combinationally for the index currently presented. The function raises one-cycle pulses on `irq_req`, and a downstream transaction builder takes the descriptors over a valid/ready handshake.

Two parameters fix the layout: 64-bit address capability and per-vector masking capability. They decide which register sits at each index, and both are reported read-only in the header. A request waits as a pending bit while its vector is masked, while messages are disabled, or while the output is still holding an earlier message. The lowest-numbered sendable vector goes out first. A zero upper address gives a message with a 32-bit address.

Top module: `msi_cap_unit`

## Requirements
- R1: After reset the header (index 0) reads 0x01807005 with default parameters (0x01007005 without 64-bit capability), every other index reads 0, and `msg_valid` is 0.
- R2: In the header, only bit 16 (message enable) is writable. The capability ID 0x05 in bits [7:0], the next pointer 0x70 in bits [15:8], bit 23 (64-bit capable), bit 24 (masking capable) and all other bits ignore writes.
- R3: Index 1 (offset 0x04) holds the lower message address. Bits [1:0] always read 0, and `msg_addr[1:0]` is always 0.
- R4: With 64-bit capability, indices 2, 3, 4 and 5 hold the upper address, the data, the mask and the pending bits. Without it, index 2 holds the data (extended data in [31:16], data in [15:0]), index 3 the mask and index 4 the pending bits. Indices outside the layout read 0 and ignore writes. Mask bits at or above NUM_VEC read 0.
- R5: A request on an unmasked vector while enable is set, with the output idle, raises `msg_valid` at the next clock edge. The descriptor carries the data register as `msg_data` and the vector number as `msg_vec`, and exactly one message is produced.
- R6: A non-zero upper address gives `msg_addr` = {upper, lower} with `msg_is64` = 1. A zero upper address, or no 64-bit capability, gives `msg_addr[63:32]` = 0 with `msg_is64` = 0.
- R7: A request on a masked vector sets its pending bit and sends nothing. Clearing the mask sends the message one edge after the mask register changes, and the pending bit clears.
- R8: The pending register ignores configuration writes.
- R9: While `msg_valid` is high and `msg_ready` is low, all descriptor fields hold. A message is taken at an edge where both are high.
- R10: A request while enable is clear sets the pending bit, and no message goes out until enable is set.
- R11: Several sendable pending vectors leave in ascending vector order, back to back. Repeated requests on a vector that is already pending merge into one message.
- R12: Address and data are captured when a message is launched. Register writes made while the message is held do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Dword index (byte offset / 4) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| irq_req | input | NUM_VEC | Per-vector request pulses |
| msg_valid | output | 1 | Descriptor valid |
| msg_ready | input | 1 | Descriptor accepted when high with valid |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data word |
| msg_is64 | output | 1 | Address needs the 64-bit form |
| msg_vec | output | 5 | Vector number of the message |

## Verification
The assertions assume that `msg_ready` is driven to a known level each cycle and that `irq_req` only uses bits below NUM_VEC. They also assume configuration writes are single-cycle strobes whose index fits the 3-bit port. The bench changes every input at the falling clock edge. It holds `msg_ready` low while it inspects a held descriptor and raises it for exactly one cycle to accept. Random rounds draw the vector, the mask choice, the data and the upper address from a fixed seed, so the held-output and alignment properties are exercised with both zero and non-zero upper addresses.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam int VEC_IDX_W = 5;

    localparam logic [2:0] IDX_HDR     = 3'd0;
    localparam logic [2:0] IDX_ADDR_LO = 3'd1;
    localparam logic [2:0] IDX_ADDR_HI = 3'd2;

    typedef struct packed {
        logic [63:0]          addr;
        logic [31:0]          data;
        logic                 is64;
        logic [VEC_IDX_W-1:0] vec;
    } msg_t;

    // Data register index; mask and pending follow it directly
    function automatic logic [2:0] data_index(input bit wide_addr);
        return wide_addr ? 3'd3 : 3'd2;
    endfunction

endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter int       NUM_VEC  = 4,
    parameter bit       CAP_64   = 1'b1,
    parameter bit       CAP_MASK = 1'b1,
    parameter bit [7:0] CAP_ID   = 8'h05,
    parameter bit [7:0] NEXT_PTR = 8'h70
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         addr,
    input  logic [31:0]        wdata,
    input  logic [NUM_VEC-1:0] pend,
    output logic [31:0]        rdata,
    output logic               msg_en,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic [NUM_VEC-1:0] mask
);

    localparam logic [2:0] DATA_IDX = data_index(CAP_64);
    localparam logic [2:0] MASK_IDX = DATA_IDX + 3'd1;
    localparam logic [2:0] PEND_IDX = DATA_IDX + 3'd2;

    typedef struct packed {
        logic               en;
        logic [29:0]        lo;
        logic [31:0]        hi;
        logic [31:0]        data;
        logic [NUM_VEC-1:0] mask;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (addr == IDX_HDR)                 r_d.en   = wdata[16];
            if (addr == IDX_ADDR_LO)             r_d.lo   = wdata[31:2];
            if (CAP_64 && addr == IDX_ADDR_HI)   r_d.hi   = wdata;
            if (addr == DATA_IDX)                r_d.data = wdata;
            if (CAP_MASK && addr == MASK_IDX)    r_d.mask = wdata[NUM_VEC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == IDX_HDR)
            rdata = {7'b0, CAP_MASK, CAP_64, 6'b0, r_q.en, NEXT_PTR, CAP_ID};
        else if (addr == IDX_ADDR_LO)
            rdata = {r_q.lo, 2'b00};
        else if (CAP_64 && addr == IDX_ADDR_HI)
            rdata = r_q.hi;
        else if (addr == DATA_IDX)
            rdata = r_q.data;
        else if (CAP_MASK && addr == MASK_IDX)
            rdata[NUM_VEC-1:0] = r_q.mask;
        else if (CAP_MASK && addr == PEND_IDX)
            rdata[NUM_VEC-1:0] = pend;
    end

    assign msg_en   = r_q.en;
    assign msg_addr = {(CAP_64 ? r_q.hi : 32'h0), r_q.lo, 2'b00};
    assign msg_data = r_q.data;
    assign mask     = CAP_MASK ? r_q.mask : '0;

endmodule

// File: rtl/msi_pick_lowest.sv
module msi_pick_lowest
    import msi_cap_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]         req,
    output logic                 any,
    output logic [VEC_IDX_W-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = VEC_IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/msi_msg_engine.sv
module msi_msg_engine
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] irq,
    input  logic [NUM_VEC-1:0] mask,
    input  logic               en,
    input  logic [63:0]        addr64,
    input  logic [31:0]        data32,
    input  logic               out_ready,
    output logic [NUM_VEC-1:0] pend,
    output logic               out_valid,
    output msg_t               out_msg
);

    localparam logic [NUM_VEC-1:0] LSB_ONE = NUM_VEC'(1);

    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
        logic               valid;
        msg_t               msg;
    } eng_t;

    eng_t e_q, e_d;

    logic [NUM_VEC-1:0]   cand;
    logic [NUM_VEC-1:0]   sendable;
    logic                 any_send;
    logic [VEC_IDX_W-1:0] pick;

    assign cand     = e_q.pend | irq;
    assign sendable = cand & ~mask & {NUM_VEC{en}};

    msi_pick_lowest #(.N(NUM_VEC)) u_pick (
        .req (sendable),
        .any (any_send),
        .idx (pick)
    );

    always_comb begin
        e_d       = e_q;
        e_d.pend  = cand;
        e_d.valid = e_q.valid && !out_ready;
        if ((!e_q.valid || out_ready) && any_send) begin
            e_d.valid     = 1'b1;
            e_d.msg.addr  = addr64;
            e_d.msg.data  = data32;
            e_d.msg.is64  = (addr64[63:32] != 32'h0);
            e_d.msg.vec   = pick;
            e_d.pend      = cand & ~(LSB_ONE << pick);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign pend      = e_q.pend;
    assign out_valid = e_q.valid;
    assign out_msg   = e_q.msg;

endmodule

// File: rtl/msi_cap_unit.sv
module msi_cap_unit
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC  = 4,
    parameter bit CAP_64   = 1'b1,
    parameter bit CAP_MASK = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic [2:0]           cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic [NUM_VEC-1:0]   irq_req,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [63:0]          msg_addr,
    output logic [31:0]          msg_data,
    output logic                 msg_is64,
    output logic [VEC_IDX_W-1:0] msg_vec
);

    logic               msg_en;
    logic [63:0]        reg_addr;
    logic [31:0]        reg_data;
    logic [NUM_VEC-1:0] reg_mask;
    logic [NUM_VEC-1:0] pend;
    msg_t               held;

    msi_cap_regs #(
        .NUM_VEC  (NUM_VEC),
        .CAP_64   (CAP_64),
        .CAP_MASK (CAP_MASK)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .pend     (pend),
        .rdata    (cfg_rdata),
        .msg_en   (msg_en),
        .msg_addr (reg_addr),
        .msg_data (reg_data),
        .mask     (reg_mask)
    );

    msi_msg_engine #(.NUM_VEC(NUM_VEC)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (irq_req),
        .mask      (reg_mask),
        .en        (msg_en),
        .addr64    (reg_addr),
        .data32    (reg_data),
        .out_ready (msg_ready),
        .pend      (pend),
        .out_valid (msg_valid),
        .out_msg   (held)
    );

    assign msg_addr = held.addr;
    assign msg_data = held.data;
    assign msg_is64 = held.is64;
    assign msg_vec  = held.vec;

endmodule

// File: rtl/msi_cap_unit_chk.sv
module msi_cap_unit_chk #(
    parameter int NUM_VEC = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  cfg_addr,
    input logic [31:0] cfg_rdata,
    input logic        msg_en,
    input logic        msg_valid,
    input logic        msg_ready,
    input logic [63:0] msg_addr,
    input logic [31:0] msg_data,
    input logic        msg_is64,
    input logic [4:0]  msg_vec
);

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)
                                    && $stable(msg_is64) && $stable(msg_vec));

    a_r3_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_addr[1:0] == 2'b00);

    a_r6_flag_matches_upper: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_is64 == (msg_addr[63:32] != 32'h0));

    a_r10_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(msg_en));

    a_r5_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> 32'(msg_vec) < NUM_VEC);

    a_r4_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr >= 3'd6 |-> cfg_rdata == 32'h0);

endmodule

bind msi_cap_unit msi_cap_unit_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .msg_en    (msg_en),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .msg_is64  (msg_is64),
    .msg_vec   (msg_vec)
);

// File: tb/msi_cap_unit_test.sv
`timescale 1ns/1ps
module msi_cap_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  irq = '0;
    logic        ready_a = 1'b0, ready_b = 1'b0;
    logic [31:0] rdata_a, rdata_b;
    logic        valid_a, valid_b, is64_a, is64_b;
    logic [63:0] addr_a, addr_b;
    logic [31:0] data_a, data_b;
    logic [4:0]  vec_a, vec_b;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    msi_cap_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr && !sel), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_a), .irq_req(sel ? 4'h0 : irq),
        .msg_valid(valid_a), .msg_ready(ready_a), .msg_addr(addr_a), .msg_data(data_a),
        .msg_is64(is64_a), .msg_vec(vec_a)
    );

    msi_cap_unit #(.CAP_64(1'b0)) uut_b (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr && sel), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_b), .irq_req(sel ? irq : 4'h0),
        .msg_valid(valid_b), .msg_ready(ready_b), .msg_addr(addr_b), .msg_data(data_b),
        .msg_is64(is64_b), .msg_vec(vec_b)
    );

    function automatic logic [31:0] exp_hdr(bit cap64, bit en);
        return 32'h01007005 | (cap64 ? 32'h00800000 : 32'h0) | (en ? 32'h00010000 : 32'h0);
    endfunction

    function automatic logic [63:0] exp_addr(logic [31:0] hi, logic [31:0] lo);
        return {hi, lo[31:2], 2'b00};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] v);
        @(negedge clk);
        cfg_addr = 3'(idx); cfg_wdata = v; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(int idx, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = 3'(idx);
        #0.5;
        v = sel ? rdata_b : rdata_a;
    endtask

    task automatic pulse(int v);
        @(negedge clk);
        irq = 4'(1 << v);
        @(negedge clk);
        irq = '0;
    endtask

    task automatic accept();
        @(negedge clk);
        if (sel) ready_b = 1'b1; else ready_a = 1'b1;
        @(negedge clk);
        ready_a = 1'b0; ready_b = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] lo, hi, dat;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, v); chk("R1 header", v, exp_hdr(1, 0));
        for (int i = 1; i < 8; i++) begin rd(i, v); chk("R1 zero", v, 0); end
        chk("R1 valid", valid_a, 0);

        // R2 read-only header fields
        wr(0, 32'hFFFFFFFF); rd(0, v); chk("R2 header all ones", v, exp_hdr(1, 1));
        wr(0, 32'h0);        rd(0, v); chk("R2 header zero", v, exp_hdr(1, 0));
        wr(0, 32'h00010000);

        // R3 lower address alignment
        lo = 32'h12345677;
        wr(1, lo); rd(1, v); chk("R3 addr lo", v, 32'h12345674);

        // R4 layout, holes, mask width
        dat = 32'hCAFE0001;
        wr(3, dat); wr(2, 32'h0);
        wr(6, 32'hFFFFFFFF); rd(6, v); chk("R4 hole 6", v, 0);
        wr(7, 32'hFFFFFFFF); rd(7, v); chk("R4 hole 7", v, 0);
        wr(4, 32'hFFFFFFFF); rd(4, v); chk("R4 mask width", v, 32'hF);
        rd(3, v); chk("R4 data at 3", v, dat);
        wr(4, 32'h0);

        // R5 / R6 / R9 / R12 basic message
        pulse(1);
        chk("R5 valid", valid_a, 1);
        chk("R5 data", data_a, dat);
        chk("R5 vec", vec_a, 1);
        chk("R6 addr 32", addr_a, exp_addr(0, lo));
        chk("R6 is64 0", is64_a, 0);
        wr(3, 32'h11111111);
        @(negedge clk);
        chk("R9 held valid", valid_a, 1);
        chk("R12 data captured", data_a, dat);
        accept();
        chk("R5 single message", valid_a, 0);
        wr(3, dat);

        // R6 upper address
        wr(2, 32'h9);
        pulse(0);
        chk("R6 addr 64", addr_a, exp_addr(32'h9, lo));
        chk("R6 is64 1", is64_a, 1);
        accept();
        wr(2, 32'h0);

        // R7 / R8 masked vector
        wr(4, 32'h4);
        pulse(2);
        chk("R7 masked no msg", valid_a, 0);
        rd(5, v); chk("R7 pending set", v, 32'h4);
        wr(5, 32'h0); rd(5, v); chk("R8 pending read-only", v, 32'h4);
        wr(4, 32'h0);
        @(negedge clk);
        chk("R7 unmask sends", valid_a, 1);
        chk("R7 unmask vec", vec_a, 2);
        rd(5, v); chk("R7 pending cleared", v, 0);
        accept();

        // R11 ordering and merging
        wr(4, 32'hF);
        pulse(3); pulse(1); pulse(3); pulse(2);
        rd(5, v); chk("R11 pending", v, 32'hE);
        wr(4, 32'h0);
        @(negedge clk);
        chk("R11 first vec", vec_a, 1);
        accept(); chk("R11 second vec", vec_a, 2); chk("R11 second valid", valid_a, 1);
        accept(); chk("R11 third vec", vec_a, 3); chk("R11 third valid", valid_a, 1);
        accept(); chk("R11 merged", valid_a, 0);

        // R10 enable gating
        wr(0, 32'h0);
        pulse(0);
        chk("R10 no msg when disabled", valid_a, 0);
        rd(5, v); chk("R10 pending", v, 32'h1);
        wr(0, 32'h00010000);
        @(negedge clk);
        chk("R10 sends on enable", valid_a, 1);
        chk("R10 vec", vec_a, 0);
        accept();

        // Random rounds
        for (int k = 0; k < 40; k++) begin
            int vv;
            bit msk;
            vv  = int'($urandom % 4);
            msk = 1'($urandom % 2);
            dat = $urandom;
            hi  = ($urandom % 2) ? $urandom : 32'h0;
            lo  = $urandom;
            wr(1, lo); wr(2, hi); wr(3, dat);
            wr(4, msk ? 32'(1 << vv) : 32'h0);
            pulse(vv);
            if (msk) begin
                chk("R7 rand masked", valid_a, 0);
                wr(4, 32'h0);
                @(negedge clk);
            end
            chk("R5 rand valid", valid_a, 1);
            chk("R5 rand data", data_a, dat);
            chk("R5 rand vec", vec_a, 5'(vv));
            chk("R6 rand addr", addr_a, exp_addr(hi, lo));
            chk("R6 rand flag", is64_a, hi != 0);
            accept();
            chk("R9 rand accepted", valid_a, 0);
        end

        // 32-bit layout instance
        sel = 1'b1;
        rd(0, v); chk("R1 header 32", v, exp_hdr(0, 0));
        wr(2, 32'hABCD1234); rd(2, v); chk("R4 data at 2", v, 32'hABCD1234);
        wr(3, 32'hFF); rd(3, v); chk("R4 mask at 3", v, 32'hF);
        wr(5, 32'hFFFFFFFF); rd(5, v); chk("R4 hole 5 in 32", v, 0);
        wr(3, 32'h0); wr(0, 32'h00010000); wr(1, 32'h40);
        pulse(3);
        chk("R5 32 valid", valid_b, 1);
        chk("R6 32 addr", addr_b, 64'h40);
        chk("R6 32 flag", is64_b, 0);
        chk("R4 32 data", data_b, 32'hABCD1234);
        wr(3, 32'h2);
        pulse(1);
        accept();
        rd(4, v); chk("R7 pending at 4", v, 32'h2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule